// File: doc/BRIEF.md
# Indexed Vector Register File

This block holds a small set of vector registers in which every register is a list of records. Each record is one packed SIMD word. Instructions never give a record index. An instruction names a register, sees only the record under that register's own current pointer, and the pointer moves forward by one each time the register is used. Scalar-style SIMD code can therefore walk through vector data one record per use, with no index arithmetic.

A register is set up in one of two ways. A load command sets its length, and the records of a strided memory read are then streamed in through the fill port. An allocate command marks it as a store vector, so that records written through its pointer can later be streamed out through the drain port. The drain port uses a valid/ready handshake and feeds the store path. Address generation, memory and the SIMD arithmetic all sit outside this block. Each register has an end-of-vector flag. A pointer-reset input lets a loop go back to record 0.

Top module: `ivrf`

## Requirements
- R1: After reset every end-of-vector flag is high (length 0), and `fill_ready`, `drain_valid` and `acc_err` are low.
- R2: A `cmd_go` with `cmd_store`=0 sets the target pointer to record 0 and latches `cmd_len` (values above DEPTH are clamped to DEPTH). `fill_ready` is high from the next cycle. Exactly `cmd_len` accepted fill beats are written to records 0, 1, 2, ... in arrival order, and then `fill_ready` drops.
- R3: With `src_en` set, `src_data` in the same cycle is the record under the named register's pointer, and that pointer advances by one at the clock edge.
- R4: With `dst_en` set, `dst_data` is written to the record under the named register's pointer, and the pointer advances by one. If one register is both source and destination in a cycle, the source sees the old record, the write goes to that same record, and the pointer advances only once.
- R5: Each register has an independent pointer. Using one register never moves the pointer of another.
- R6: `eov[r]` is high whenever register r's pointer equals its length, including a length of 0. An access to such a register returns 0 on `src_data`, writes nothing, leaves the pointer unchanged and raises `acc_err` in the same cycle. The flag stays high until a command or pointer reset.
- R7: `ptr_rst[r]` returns register r's pointer to record 0 and clears `eov[r]` when its length is non-zero. In the same cycle, a command to register r takes precedence over `ptr_rst[r]`, and `ptr_rst[r]` takes precedence over a use of r.
- R8: A `cmd_go` with `cmd_store`=1 sets the pointer to 0, latches the length and marks the register as a store vector. It does not open the fill port.
- R9: `drain_go` on a store vector with non-zero length streams records 0 through length-1 on `drain_data`. `drain_last` is high on the final record, and data is held while `drain_ready` is low. `drain_go` on a register not marked as a store vector is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Load or allocate command strobe |
| cmd_store | input | 1 | 0 = load, 1 = allocate as store vector |
| cmd_reg | input | RW | Target register of the command |
| cmd_len | input | LW | Record count of the vector |
| fill_valid | input | 1 | Fill record present |
| fill_data | input | WIDTH | Fill record |
| fill_ready | output | 1 | Fill port accepting records |
| src_en | input | 1 | Source use of a register |
| src_reg | input | RW | Source register |
| src_data | output | WIDTH | Record under the source pointer |
| dst_en | input | 1 | Destination use of a register |
| dst_reg | input | RW | Destination register |
| dst_data | input | WIDTH | Record to write |
| ptr_rst | input | NREG | Per-register pointer reset |
| eov | output | NREG | Per-register end-of-vector flags |
| acc_err | output | 1 | Access past the end of a vector |
| drain_go | input | 1 | Start draining a store vector |
| drain_reg | input | RW | Register to drain |
| drain_valid | output | 1 | Drain record present |
| drain_ready | input | 1 | Consumer accepts drain record |
| drain_data | output | WIDTH | Drain record |
| drain_last | output | 1 | Final record of the drain |

## Verification
The hardest case to reach is a single instruction that uses one register as both source and destination. A wrong design that advances the pointer twice looks correct until a later read lands one record too far. The bench loads a two-record vector, issues the combined use, and then reads the second record. It then resets the pointer and reads record 0 to confirm that the write landed where the read came from. A second case is a drain held off by backpressure. The bench holds `drain_ready` low for several cycles and checks that the record and flags do not move.

// File: rtl/ivrf.sv
module ivrf #(
  parameter int NREG  = 4,
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic             cmd_store,
  input  logic [RW-1:0]    cmd_reg,
  input  logic [LW-1:0]    cmd_len,
  input  logic             fill_valid,
  input  logic [WIDTH-1:0] fill_data,
  output logic             fill_ready,
  input  logic             src_en,
  input  logic [RW-1:0]    src_reg,
  output logic [WIDTH-1:0] src_data,
  input  logic             dst_en,
  input  logic [RW-1:0]    dst_reg,
  input  logic [WIDTH-1:0] dst_data,
  input  logic [NREG-1:0]  ptr_rst,
  output logic [NREG-1:0]  eov,
  output logic             acc_err,
  input  logic             drain_go,
  input  logic [RW-1:0]    drain_reg,
  output logic             drain_valid,
  input  logic             drain_ready,
  output logic [WIDTH-1:0] drain_data,
  output logic             drain_last
);
  logic [WIDTH-1:0] mem [NREG][DEPTH];
  logic [LW-1:0]    ptr [NREG];
  logic [LW-1:0]    len [NREG];
  logic [NREG-1:0]  st_v;

  logic          fill_act;
  logic [RW-1:0] fill_reg;
  logic [LW-1:0] fill_cnt;
  logic          dr_act;
  logic [RW-1:0] dr_reg;
  logic [LW-1:0] dr_cnt;

  wire [LW-1:0] len_in = (cmd_len > LW'(DEPTH)) ? LW'(DEPTH) : cmd_len;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [LW-1:0] ptr_q, len_q;
    logic          st_q;
    wire hit  = cmd_go && (cmd_reg == RW'(r));
    wire used = (src_en && (src_reg == RW'(r))) || (dst_en && (dst_reg == RW'(r)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q <= '0;
        len_q <= '0;
        st_q  <= 1'b0;
      end else if (hit) begin
        ptr_q <= '0;
        len_q <= len_in;
        st_q  <= cmd_store;
      end else if (ptr_rst[r]) begin
        ptr_q <= '0;
      end else if (used && (ptr_q < len_q)) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end

    assign ptr[r]  = ptr_q;
    assign len[r]  = len_q;
    assign st_v[r] = st_q;
    assign eov[r]  = (ptr_q >= len_q);
  end

  assign src_data = (src_en && !eov[src_reg]) ? mem[src_reg][ptr[src_reg][AW-1:0]] : '0;
  assign acc_err  = (src_en && eov[src_reg]) || (dst_en && eov[dst_reg]);

  always_ff @(posedge clk) begin
    if (dst_en && !eov[dst_reg])
      mem[dst_reg][ptr[dst_reg][AW-1:0]] <= dst_data;
    if (fill_act && fill_valid)
      mem[fill_reg][fill_cnt[AW-1:0]] <= fill_data;
  end

  assign fill_ready = fill_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_act <= 1'b0;
      fill_reg <= '0;
      fill_cnt <= '0;
    end else if (cmd_go && !cmd_store) begin
      fill_act <= (len_in != '0);
      fill_reg <= cmd_reg;
      fill_cnt <= '0;
    end else if (fill_act && fill_valid) begin
      fill_cnt <= fill_cnt + 1'b1;
      if (fill_cnt == len[fill_reg] - 1'b1) fill_act <= 1'b0;
    end
  end

  assign drain_valid = dr_act;
  assign drain_data  = mem[dr_reg][dr_cnt[AW-1:0]];
  assign drain_last  = dr_act && (dr_cnt == len[dr_reg] - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_act <= 1'b0;
      dr_reg <= '0;
      dr_cnt <= '0;
    end else if (!dr_act) begin
      if (drain_go && st_v[drain_reg] && (len[drain_reg] != '0)) begin
        dr_act <= 1'b1;
        dr_reg <= drain_reg;
        dr_cnt <= '0;
      end
    end else if (drain_ready) begin
      if (drain_last) dr_act <= 1'b0;
      dr_cnt <= dr_cnt + 1'b1;
    end
  end
endmodule

module ivrf_chk #(
  parameter int NREG  = 4,
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_go,
  input logic [RW-1:0]    cmd_reg,
  input logic [LW-1:0]    cmd_len,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [NREG-1:0]  ptr_rst,
  input logic [NREG-1:0]  eov,
  input logic             drain_valid,
  input logic             drain_ready,
  input logic [WIDTH-1:0] drain_data,
  input logic             drain_last
);
  // R2
  load_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && (cmd_len != '0) |=> !eov[$past(cmd_reg)]);
  // R2
  fill_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_ready) |-> $past(fill_valid || cmd_go));
  // R6
  eov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eov[0] && !ptr_rst[0] && !cmd_go |=> eov[0]);
  // R7
  ptr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst[0] && !cmd_go && !eov[0] |=> !eov[0]);
  // R9
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid && !drain_ready |=> drain_valid && $stable(drain_data) && $stable(drain_last));
  // R9
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid && drain_ready && drain_last |=> !drain_valid);
endmodule

bind ivrf ivrf_chk #(.NREG(NREG), .DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (.*);

// File: tb/ivrf_tb_top.sv
module ivrf_tb_top;
  localparam int CLK_P = 10;
  localparam int NREG = 4, DEPTH = 8, WIDTH = 32;
  localparam int RW = 2, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_go = 0, cmd_store = 0;
  logic [RW-1:0] cmd_reg = '0;
  logic [LW-1:0] cmd_len = '0;
  logic fill_valid = 0;
  logic [WIDTH-1:0] fill_data = '0;
  logic fill_ready;
  logic src_en = 0;
  logic [RW-1:0] src_reg = '0;
  logic [WIDTH-1:0] src_data;
  logic dst_en = 0;
  logic [RW-1:0] dst_reg = '0;
  logic [WIDTH-1:0] dst_data = '0;
  logic [NREG-1:0] ptr_rst = '0;
  logic [NREG-1:0] eov;
  logic acc_err;
  logic drain_go = 0;
  logic [RW-1:0] drain_reg = '0;
  logic drain_valid, drain_ready = 0, drain_last;
  logic [WIDTH-1:0] drain_data;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ivrf #(.NREG(NREG), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic load(input int r, input int n, input logic [31:0] base);
    cmd_go = 1; cmd_store = 0; cmd_reg = RW'(r); cmd_len = LW'(n);
    cyc();
    cmd_go = 0;
    for (int i = 0; i < n; i++) begin
      fill_valid = 1; fill_data = base + 32'(i);
      cyc();
    end
    fill_valid = 0;
  endtask

  task automatic rd(input int r, input logic [31:0] exp, input string req);
    src_en = 1; src_reg = RW'(r);
    #1 chk(req, "src_data", src_data, exp);
    cyc();
    src_en = 0;
  endtask

  task automatic pr(input int r);
    ptr_rst[r] = 1'b1; cyc(); ptr_rst = '0;
  endtask

  task automatic t_reset();
    chk("R1", "eov", 32'(eov), 32'hF);
    chk("R1", "fill_ready", 32'(fill_ready), 0);
    chk("R1", "drain_valid", 32'(drain_valid), 0);
    chk("R1", "acc_err", 32'(acc_err), 0);
  endtask

  task automatic t_load();
    cmd_go = 1; cmd_store = 0; cmd_reg = 1; cmd_len = 3;
    cyc(); cmd_go = 0;
    chk("R2", "fill_ready open", 32'(fill_ready), 1);
    chk("R2", "eov1 cleared", 32'(eov[1]), 0);
    for (int i = 0; i < 3; i++) begin
      fill_valid = 1; fill_data = 32'h10 + 32'(i); cyc();
    end
    fill_valid = 0;
    chk("R2", "fill_ready closed", 32'(fill_ready), 0);
    for (int i = 0; i < 3; i++) rd(1, 32'h10 + 32'(i), "R3");
    chk("R6", "eov1 at end", 32'(eov[1]), 1);
  endtask

  task automatic t_srcdst();
    load(2, 2, 32'h200);
    src_en = 1; src_reg = 2; dst_en = 1; dst_reg = 2; dst_data = 32'h55;
    #1 chk("R4", "old record on shared use", src_data, 32'h200);
    chk("R4", "acc_err shared", 32'(acc_err), 0);
    cyc(); src_en = 0; dst_en = 0;
    rd(2, 32'h201, "R4 single advance");
    chk("R4", "eov2", 32'(eov[2]), 1);
    pr(2);
    chk("R7", "eov2 after ptr_rst", 32'(eov[2]), 0);
    rd(2, 32'h55, "R7 record0 rewritten");
  endtask

  task automatic t_indep();
    load(0, 4, 32'h100);
    load(3, 4, 32'h300);
    rd(0, 32'h100, "R5");
    rd(3, 32'h300, "R5");
    rd(3, 32'h301, "R5");
    rd(3, 32'h302, "R5");
    rd(0, 32'h101, "R5 other ptr untouched");
  endtask

  task automatic t_eov();
    dst_en = 1; dst_reg = 1; dst_data = 32'hDEAD;
    #1 chk("R6", "acc_err on write past end", 32'(acc_err), 1);
    cyc(); dst_en = 0;
    src_en = 1; src_reg = 1;
    #1 chk("R6", "src_data past end", src_data, 0);
    chk("R6", "acc_err on read past end", 32'(acc_err), 1);
    cyc(); src_en = 0;
    chk("R6", "eov1 held", 32'(eov[1]), 1);
    pr(1);
    rd(1, 32'h10, "R6 write ignored");
    load(3, 0, 32'h0);
    chk("R6", "eov3 len0", 32'(eov[3]), 1);
    chk("R6", "fill_ready len0", 32'(fill_ready), 0);
    src_en = 1; src_reg = 3;
    #1 chk("R6", "acc_err len0", 32'(acc_err), 1);
    cyc(); src_en = 0;
  endtask

  task automatic t_store();
    cmd_go = 1; cmd_store = 1; cmd_reg = 0; cmd_len = 3;
    cyc(); cmd_go = 0; cmd_store = 0;
    chk("R8", "no fill on allocate", 32'(fill_ready), 0);
    chk("R8", "eov0 cleared", 32'(eov[0]), 0);
    for (int i = 0; i < 3; i++) begin
      dst_en = 1; dst_reg = 0; dst_data = 32'hA0 + 32'(i); cyc();
    end
    dst_en = 0;
    chk("R8", "eov0 after writes", 32'(eov[0]), 1);
    drain_go = 1; drain_reg = 1; cyc(); drain_go = 0;
    chk("R9", "drain of load vector ignored", 32'(drain_valid), 0);
    drain_ready = 0; drain_go = 1; drain_reg = 0; cyc(); drain_go = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R9", "hold valid", 32'(drain_valid), 1);
      chk("R9", "hold data", drain_data, 32'hA0);
      chk("R9", "hold last", 32'(drain_last), 0);
      cyc();
    end
    drain_ready = 1;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R9", "drain data", drain_data, 32'hA0 + 32'(i));
      chk("R9", "drain last", 32'(drain_last), (i == 2) ? 1 : 0);
      cyc();
    end
    drain_ready = 0;
    chk("R9", "drain done", 32'(drain_valid), 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_load();
    t_srcdst();
    t_indep();
    t_eov();
    t_store();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule